// File: doc/BRIEF.md
# Maskable Interrupt Controller with Master Enable

The block gathers interrupt requests from up to fourteen peripheral sources and turns them into one pending-interrupt line for a processor. Each clock the peripherals present a request bitmask. A request bit is captured into a sticky flag register only when three conditions hold: the same bit is set in the enable mask, the master enable is on, and the processor-side mask input is low. The pending line is high while the master enable is on, at least one flag is set and the processor-side mask input is low.

Software reaches three registers through a small single-cycle register port. A register is selected by a 2-bit address, and a write takes effect at the next clock edge. Read data is combinational from the selected register. Address 0 is the master enable. Address 1 is the enable mask. Address 2 is the flag register, where writing a 1 to a bit clears that flag. Address 3 is unused. Source positions are fixed: VBlank on bit 0, HBlank on bit 1, vertical count match on bit 2, timers 0 to 3 on bits 3 to 6, serial on bit 7, DMA channels 0 to 3 on bits 8 to 11, keypad on bit 12 and cartridge on bit 13.

Top module: `irq_mask_ctrl`

## Requirements
- R1: Reset does the following. The master enable, the enable mask and the flags are all zero. Every address reads 0x0000. `irq_o` is low.
- R2: A write to address 0 does the following. Write data that is not zero sets the master enable, and zero clears it. Address 0 reads back 0x0001 when the master enable is set and 0x0000 when it is clear.
- R3: A write to address 1 replaces the whole enable mask with write data bits 13:0. Address 1 reads back the mask, and bits 15:14 always read 0.
- R4: A write to address 2 clears each flag whose bit is 1 in the write data. Flags whose write-data bit is 0 keep their value. Address 2 reads back the flags, and bits 15:14 always read 0.
- R5: A request bit that is high in a cycle sets its flag at the clock edge that ends that cycle. This happens only when its enable-mask bit is 1, the master enable is set and `cpu_irq_mask_i` is low. The flag is visible on the following read.
- R6: Requests have no effect on the flags in a cycle where the master enable is clear or `cpu_irq_mask_i` is high. Requests whose enable-mask bit is 0 also have no effect.
- R7: `irq_o` is high exactly when the master enable is set, at least one flag is set and `cpu_irq_mask_i` is low.
- R8: Sometimes a write to address 2 clears a flag in the same cycle that a captured request sets it. In that case the flag is 1 after the clock edge.
- R9: A write to address 3 changes no register, and address 3 reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 14 | Per-source request bitmask, sampled every cycle |
| cpu_irq_mask_i | input | 1 | Processor-side mask; when high, stops both capture and `irq_o` |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 master enable, 1 enable mask, 2 flags, 3 unused |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| irq_o | output | 1 | Pending interrupt to the processor |

## Verification
The assertions check four behaviours on every cycle:
- a captured request always shows as a set flag one edge later, including when a clear of the same bit arrives in that cycle;
- no flag rises while the master enable is off or the processor mask is high;
- write-one-to-clear takes effect when no request competes;
- `irq_o` never rises while the processor mask is high or the master enable is off.

Some behaviours only the bench's scenarios can show. These are the exact read-back values of each register, the read-only zero bits 15:14 under all-ones writes, the absence of any effect from writes to the unused address, and a walk of each of the fourteen source positions from request through capture to clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned IRQC_NUM_SRC = 14;
  localparam int unsigned IRQC_DATA_W  = 16;
  localparam int unsigned IRQC_ADDR_W  = 2;

  typedef enum logic [IRQC_ADDR_W-1:0] {
    REG_MEN  = 2'd0,
    REG_MASK = 2'd1,
    REG_FLAG = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // source positions
  localparam int unsigned SRC_VBLANK  = 0;
  localparam int unsigned SRC_HBLANK  = 1;
  localparam int unsigned SRC_VMATCH  = 2;
  localparam int unsigned SRC_TIMER0  = 3;
  localparam int unsigned SRC_SERIAL  = 7;
  localparam int unsigned SRC_DMA0    = 8;
  localparam int unsigned SRC_KEYPAD  = 12;
  localparam int unsigned SRC_CART    = 13;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = IRQC_NUM_SRC,
  parameter int unsigned DATA_W  = IRQC_DATA_W,
  parameter int unsigned ADDR_W  = IRQC_ADDR_W
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              men_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [NUM_SRC-1:0] flag_i,
  output logic              men_we_o,
  output logic              men_val_o,
  output logic              mask_we_o,
  output logic [NUM_SRC-1:0] mask_val_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic sel_men, sel_mask, sel_flag;

  assign sel_men  = (addr_i == REG_MEN);
  assign sel_mask = (addr_i == REG_MASK);
  assign sel_flag = (addr_i == REG_FLAG);

  assign men_we_o   = we_i & sel_men;
  assign men_val_o  = |wdata_i;
  assign mask_we_o  = we_i & sel_mask;
  assign mask_val_o = wdata_i[NUM_SRC-1:0];
  assign clr_o      = (we_i & sel_flag) ? wdata_i[NUM_SRC-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (sel_men)       rdata_o[0]         = men_i;
    else if (sel_mask) rdata_o[NUM_SRC-1:0] = mask_i;
    else if (sel_flag) rdata_o[NUM_SRC-1:0] = flag_i;
  end
endmodule

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs #(
  parameter int unsigned NUM_SRC = irqc_pkg::IRQC_NUM_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               men_we_i,
  input  logic               men_val_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_val_i,
  output logic               men_o,
  output logic [NUM_SRC-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      men_o  <= 1'b0;
      mask_o <= '0;
    end else begin
      if (men_we_i)  men_o  <= men_val_i;
      if (mask_we_i) mask_o <= mask_val_i;
    end
  end
endmodule

// File: rtl/irqc_gate.sv
module irqc_gate #(
  parameter int unsigned NUM_SRC = irqc_pkg::IRQC_NUM_SRC
) (
  input  logic               men_i,
  input  logic               cpu_mask_i,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [NUM_SRC-1:0] flag_i,
  output logic [NUM_SRC-1:0] set_o,
  output logic               irq_o
);
  logic open_w;

  assign open_w = men_i & ~cpu_mask_i;
  assign set_o  = open_w ? (req_i & mask_i) : '0;
  assign irq_o  = open_w & (|flag_i);
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags #(
  parameter int unsigned NUM_SRC = irqc_pkg::IRQC_NUM_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flag_o
);
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[b] <= 1'b0;
      else if (set_i[b]) flag_o[b] <= 1'b1;  // set beats clear
      else if (clr_i[b]) flag_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = IRQC_NUM_SRC,
  parameter int unsigned DATA_W  = IRQC_DATA_W,
  parameter int unsigned ADDR_W  = IRQC_ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               cpu_irq_mask_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o
);
  logic               men_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] flag_q;
  logic               men_we, men_val, mask_we;
  logic [NUM_SRC-1:0] mask_val, clr_w, set_w;

  irqc_decode #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .men_i(men_q), .mask_i(mask_q), .flag_i(flag_q),
    .men_we_o(men_we), .men_val_o(men_val), .mask_we_o(mask_we),
    .mask_val_o(mask_val), .clr_o(clr_w), .rdata_o(reg_rdata_o)
  );

  irqc_ctrl_regs #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .men_we_i(men_we), .men_val_i(men_val),
    .mask_we_i(mask_we), .mask_val_i(mask_val),
    .men_o(men_q), .mask_o(mask_q)
  );

  irqc_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .men_i(men_q), .cpu_mask_i(cpu_irq_mask_i), .req_i(req_i),
    .mask_i(mask_q), .flag_i(flag_q), .set_o(set_w), .irq_o(irq_o)
  );

  irqc_flags #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_w), .clr_i(clr_w), .flag_o(flag_q)
  );
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = IRQC_NUM_SRC,
  parameter int unsigned DATA_W  = IRQC_DATA_W,
  parameter int unsigned ADDR_W  = IRQC_ADDR_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] req_i,
  input logic               cpu_mask_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_i,
  input logic               irq_i,
  input logic               men_i,
  input logic [NUM_SRC-1:0] mask_i,
  input logic [NUM_SRC-1:0] flag_i
);
  assert_men_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_MEN) |=> (men_i == ($past(wdata_i) != '0)));

  assert_mask_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_MASK) |->
      (rdata_i[DATA_W-1:NUM_SRC] == '0 && rdata_i[NUM_SRC-1:0] == mask_i));

  assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_FLAG && (req_i & mask_i) == '0)
      |=> ((flag_i & $past(wdata_i[NUM_SRC-1:0])) == '0));

  assert_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (men_i && !cpu_mask_i)
      |=> ((flag_i & $past(req_i & mask_i)) == $past(req_i & mask_i)));

  assert_no_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!men_i || cpu_mask_i) |=> ((flag_i & ~$past(flag_i)) == '0));

  assert_irq_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (men_i && !cpu_mask_i && flag_i != '0));

  assert_irq_raised_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (men_i && !cpu_mask_i && flag_i != '0) |-> irq_i);

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_FLAG && men_i && !cpu_mask_i)
      |=> ((flag_i & $past(wdata_i[NUM_SRC-1:0] & req_i & mask_i))
           == $past(wdata_i[NUM_SRC-1:0] & req_i & mask_i)));
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .cpu_mask_i(cpu_irq_mask_i),
  .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
  .rdata_i(reg_rdata_o), .irq_i(irq_o),
  .men_i(men_q), .mask_i(mask_q), .flag_i(flag_q)
);

// File: tb/irq_mask_ctrl_bench.sv
`timescale 1ns/1ps
module irq_mask_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 14;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] req = '0;
  logic            cmask = 1'b0;
  logic            we = 1'b0;
  logic [1:0]      addr = '0;
  logic [15:0]     wdata = '0;
  logic [15:0]     rdata;
  logic            irq;

  int n_cmp = 0;
  int n_bad = 0;
  int wd = 0;

  // reference state
  bit        m_men;
  int        m_mask;
  int        m_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_mask_ctrl u_irq_mask_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cpu_irq_mask_i(cmask),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_men = 0; m_mask = 0; m_flag = 0;
    end else begin
      int set_v, clr_v;
      set_v = (m_men && !cmask) ? (int'(req) & m_mask) : 0;
      clr_v = (we && addr == 2) ? int'(wdata) : 0;
      m_flag = ((m_flag & ~clr_v) | set_v) & 16'h3FFF;
      if (we && addr == 0) m_men = (wdata != 0);
      if (we && addr == 1) m_mask = int'(wdata) & 16'h3FFF;
    end
  end

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_men ? 1 : 0;
      1: return m_mask;
      2: return m_flag;
      default: return 0;
    endcase
  endfunction

  task automatic cyc(input bit w, input int a, input int d, input int r,
                     input bit cm, input string tag);
    int er;
    bit ei;
    @(negedge clk);
    we = w; addr = a[1:0]; wdata = d[15:0]; req = r[NSRC-1:0]; cmask = cm;
    #1;
    er = exp_rd(a);
    ei = m_men && (m_flag != 0) && !cm;
    n_cmp++;
    if (int'(rdata) != er || irq != ei) begin
      n_bad++;
      $display("FAIL %s: addr=%0d rdata=%h irq=%0b expected rdata=%h irq=%0b",
               tag, a, rdata, irq, er[15:0], ei);
    end
  endtask

  task automatic rd(input int a, input bit cm, input string tag);
    cyc(0, a, 0, 0, cm, tag);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    for (int a = 0; a < 4; a++) rd(a, 0, "R1");
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 4; a++) rd(a, 0, "R1");

    // R2 master enable
    cyc(1, 0, 16'h0005, 0, 0, "R2"); rd(0, 0, "R2");
    cyc(1, 0, 16'h0000, 0, 0, "R2"); rd(0, 0, "R2");
    cyc(1, 0, 16'h8000, 0, 0, "R2"); rd(0, 0, "R2");

    // R3 enable mask replace, top bits zero
    cyc(1, 1, 16'hFFFF, 0, 0, "R3"); rd(1, 0, "R3");
    cyc(1, 1, 16'h0009, 0, 0, "R3"); rd(1, 0, "R3");

    // R5 capture only enabled bits, R7 pending
    cyc(0, 2, 0, 16'h3FFF, 0, "R5"); rd(2, 0, "R5"); rd(2, 0, "R7");

    // R4 write one to clear
    cyc(1, 2, 16'h0001, 0, 0, "R4"); rd(2, 0, "R4");
    cyc(1, 2, 16'h0000, 0, 0, "R4"); rd(2, 0, "R4");
    rd(2, 1, "R7");
    cyc(1, 2, 16'hFFFF, 0, 0, "R4"); rd(2, 0, "R4");

    // R6 ignored when cpu mask high or master enable off
    cyc(0, 2, 0, 16'h3FFF, 1, "R6"); rd(2, 0, "R6");
    cyc(1, 0, 0, 0, 0, "R6");
    cyc(0, 2, 0, 16'h3FFF, 0, "R6"); rd(2, 0, "R6");
    cyc(1, 0, 1, 0, 0, "R6");
    cyc(0, 2, 0, 16'h3FF6, 0, "R6"); rd(2, 0, "R6");

    // R8 set beats clear
    cyc(0, 2, 0, 16'h0008, 0, "R8"); rd(2, 0, "R8");
    cyc(1, 2, 16'h0008, 16'h0008, 0, "R8"); rd(2, 0, "R8");
    cyc(1, 0, 0, 0, 0, "R7"); rd(2, 0, "R7");
    cyc(1, 0, 1, 0, 0, "R7"); rd(2, 0, "R7");

    // R9 unused address
    cyc(1, 3, 16'hFFFF, 0, 0, "R9"); rd(3, 0, "R9");
    for (int a = 0; a < 3; a++) rd(a, 0, "R9");

    // walk every source position (R5, R4)
    cyc(1, 1, 16'h3FFF, 0, 0, "R3");
    cyc(1, 2, 16'hFFFF, 0, 0, "R4");
    for (int i = 0; i < NSRC; i++) begin
      cyc(0, 2, 0, 1 << i, 0, "R5");
      rd(2, 0, "R5");
      cyc(1, 2, 1 << i, 0, 0, "R4");
      rd(2, 0, "R4");
    end

    // mixed patterns with mask toggling (R6, R7)
    for (int k = 0; k < 40; k++) begin
      cyc(k % 5 == 0, (k % 3), (k * 16'h1357) & 16'hFFFF,
          (k * 16'h0A5B) & 16'h3FFF, (k % 4 == 1), "R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule